// File: doc/BRIEF.md
# Byte-Packing Host Data Port Buffer

This block sits between a 16-bit host data register and a byte-serial bus engine. It holds up to four bytes per direction. On the send side the host hands over either a 16-bit word (two bytes) or, for the tail of a message, a single byte. The engine then drains the bytes one at a time, oldest first. On the receive side the engine deposits bytes one at a time. Each host read takes the two oldest bytes at once, or the last lone byte when only one is left.

A configuration input chooses the byte order of 16-bit host words, in both directions. The block does not own the status register. It issues one-cycle update pulses instead: clear transmit underflow, clear transmit-ready, clear receive-ready, set single-byte, clear receive overrun, and set access-ready. The access-ready pulse also tells the surrounding logic to leave master mode.

All data moving between host, buffer and engine uses valid/ready handshakes. A transfer happens on a rising edge where both valid and ready are high. A source may hold valid high while ready is low, and nothing is taken until ready rises. The host write port lowers ready while more than two transmit bytes are held, so a write offered then has no effect. The receive push port lowers ready when four bytes are held. The host read strobe, the configuration inputs and the pulse outputs are plain signals.

Top module: `bytepack_buf`

## Requirements
- R1: After reset both byte counts are 0, `wr_ready` and `push_ready` are 1, `pop_valid` is 0, `rd_data` is 0 and every pulse output is 0.
- R2: A word write (`wr_byte`=0) is accepted only while `tx_cnt` is at most 2, and it raises `tx_cnt` by 2. While `tx_cnt` exceeds 2, `wr_ready` is 0 and a write offered then leaves the count and the queued bytes unchanged.
- R3: With `cfg_swap`=0, bits [7:0] of a written word leave the block before bits [15:8]. With `cfg_swap`=1, bits [15:8] leave first.
- R4: A byte write (`wr_byte`=1) queues `wr_data[7:0]` behind all bytes already held and raises `tx_cnt` by 1.
- R5: `pop_valid` is 1 whenever `tx_cnt` is nonzero, and `pop_data` shows the oldest held byte. A pop lowers the count by 1, and it may coincide with a write.
- R6: In the cycle after any accepted write, `txudf_clr` pulses. `txrdy_clr` also pulses when the count after the write, before any pop in that cycle, exceeds 2.
- R7: `push_ready` is 1 while `rx_cnt` is below 4. Pushed bytes fill from `rd_data` bit 0 upward, oldest in the lowest byte lane.
- R8: With two or more bytes held, `rd_data` is {second, oldest} when `cfg_swap`=0 and {oldest, second} when `cfg_swap`=1. A read (`rd_en`) consumes those two bytes, and the remaining bytes move down.
- R9: With exactly one byte held, `rd_data` carries it in [7:0] with [15:8]=0 when `cfg_swap`=0, and in [15:8] with [7:0]=0 when `cfg_swap`=1. A read then empties the buffer and pulses `sbd_set` in the next cycle.
- R10: A read that leaves the receive side empty pulses `rxrdy_clr` in the next cycle. If `mst_rx` was 1 at that read, `ardy_set` pulses in the same cycle.
- R11: Every read, including a read of an empty buffer, pulses `ovr_clr` in the next cycle.
- R12: With no byte held, `rd_data` is 0, and a read leaves `rx_cnt` at 0 without pulsing `sbd_set`, `rxrdy_clr` or `ardy_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_swap | input | 1 | Byte order of 16-bit host words |
| mst_rx | input | 1 | Engine is in master-receive mode |
| wr_valid | input | 1 | Host write offered |
| wr_ready | output | 1 | Host write can be taken |
| wr_byte | input | 1 | 1: single-byte write, 0: word write |
| wr_data | input | 16 | Host write data |
| pop_valid | output | 1 | A transmit byte is available |
| pop_ready | input | 1 | Engine takes the transmit byte |
| pop_data | output | 8 | Oldest transmit byte |
| push_valid | input | 1 | Engine offers a received byte |
| push_ready | output | 1 | Receive side has room |
| push_data | input | 8 | Received byte |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 16 | Word a read in this cycle returns |
| tx_cnt | output | 3 | Transmit bytes held |
| rx_cnt | output | 3 | Receive bytes held |
| txudf_clr | output | 1 | Pulse: clear transmit underflow |
| txrdy_clr | output | 1 | Pulse: clear transmit-ready |
| rxrdy_clr | output | 1 | Pulse: clear receive-ready |
| sbd_set | output | 1 | Pulse: set single-byte flag |
| ovr_clr | output | 1 | Pulse: clear receive overrun |
| ardy_set | output | 1 | Pulse: set access-ready, leave master mode |

## Verification
The handshake outputs, `pop_data` and `rd_data` are combinational views of the held state. They are therefore due in the same cycle that follows the edge that changed that state. Every status pulse passes through one register, so it is due in the cycle after the edge where the write, read or push was taken.

A behavioural queue model advances on each rising edge, using the inputs driven at the previous falling edge. It records the pulses that edge should cause. All outputs are compared against the model at the next falling edge, which is exactly one register delay after the causing edge.

// File: rtl/bpk_pkg.sv
package bpk_pkg;
  localparam int HOST_W = 16;

  typedef logic [HOST_W-1:0] hword_t;
  typedef logic [7:0]        byte_t;

  // Arrange a host word so that the byte to be sent first sits in the upper lane.
  function automatic hword_t order_tx(input hword_t d, input logic swap);
    return swap ? d : {d[7:0], d[15:8]};
  endfunction

  // Build the host read word from the oldest byte and the one behind it.
  function automatic hword_t order_rx(input byte_t oldest, input byte_t second,
                                      input logic swap);
    return swap ? {oldest, second} : {second, oldest};
  endfunction
endpackage

// File: rtl/bpk_tx_side.sv
module bpk_tx_side #(
  parameter int NB = 4,
  localparam int CW = $clog2(NB + 1),
  localparam int BW = NB * 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_swap,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic               wr_byte,
  input  bpk_pkg::hword_t    wr_data,
  output logic               pop_valid,
  input  logic               pop_ready,
  output bpk_pkg::byte_t     pop_data,
  output logic [CW-1:0]      tx_cnt,
  output logic               txudf_clr,
  output logic               txrdy_clr
);
  logic [BW-1:0]   buf_q, buf_d, shifted;
  logic [CW-1:0]   cnt_q, cnt_d, wcnt;
  logic [CW+2:0]   sh;
  logic            accept, pop;

  assign wr_ready  = cnt_q <= CW'(NB - 2);
  assign pop_valid = cnt_q != '0;
  assign accept    = wr_valid && wr_ready;
  assign pop       = pop_valid && pop_ready;

  // Oldest byte sits at lane (count - 1).
  assign sh       = {cnt_q - CW'(1), 3'b000};
  assign shifted  = buf_q >> sh;
  assign pop_data = pop_valid ? shifted[7:0] : '0;

  always_comb begin
    buf_d = buf_q;
    wcnt  = cnt_q;
    if (accept) begin
      if (wr_byte) begin
        buf_d = (buf_q << 8) | BW'(wr_data[7:0]);
        wcnt  = cnt_q + CW'(1);
      end else begin
        buf_d = (buf_q << 16) | BW'(bpk_pkg::order_tx(wr_data, cfg_swap));
        wcnt  = cnt_q + CW'(2);
      end
    end
    cnt_d = pop ? wcnt - CW'(1) : wcnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q     <= '0;
      cnt_q     <= '0;
      txudf_clr <= 1'b0;
      txrdy_clr <= 1'b0;
    end else begin
      buf_q     <= buf_d;
      cnt_q     <= cnt_d;
      txudf_clr <= accept;
      txrdy_clr <= accept && (wcnt > CW'(2));
    end
  end

  assign tx_cnt = cnt_q;
endmodule

// File: rtl/bpk_rx_side.sv
module bpk_rx_side #(
  parameter int NB = 4,
  localparam int CW = $clog2(NB + 1),
  localparam int BW = NB * 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_swap,
  input  logic               mst_rx,
  input  logic               push_valid,
  output logic               push_ready,
  input  bpk_pkg::byte_t     push_data,
  input  logic               rd_en,
  output bpk_pkg::hword_t    rd_data,
  output logic [CW-1:0]      rx_cnt,
  output logic               rxrdy_clr,
  output logic               sbd_set,
  output logic               ovr_clr,
  output logic               ardy_set
);
  logic [BW-1:0] buf_q, buf_d, rbuf;
  logic [CW-1:0] cnt_q, cnt_d, rcnt;
  logic          lone, emptied, take;

  assign push_ready = cnt_q < CW'(NB);
  assign take       = push_valid && push_ready;

  always_comb begin
    if (cnt_q == '0)
      rd_data = '0;
    else if (cnt_q == CW'(1))
      rd_data = bpk_pkg::order_rx(buf_q[7:0], 8'h00, cfg_swap);
    else
      rd_data = bpk_pkg::order_rx(buf_q[7:0], buf_q[15:8], cfg_swap);
  end

  // Host read stage first, then the engine deposit lands behind what remains.
  always_comb begin
    rbuf = buf_q;
    rcnt = cnt_q;
    lone = 1'b0;
    if (rd_en) begin
      if (cnt_q == CW'(1)) begin
        rcnt = '0;
        lone = 1'b1;
      end else if (cnt_q >= CW'(2)) begin
        rcnt = cnt_q - CW'(2);
        if (cnt_q > CW'(2)) rbuf = buf_q >> 16;
      end
    end
    emptied = rd_en && (cnt_q != '0) && (rcnt == '0);
    buf_d = rbuf;
    cnt_d = rcnt;
    if (take) begin
      for (int i = 0; i < NB; i++)
        if (CW'(i) == rcnt) buf_d[8*i +: 8] = push_data;
      cnt_d = rcnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q     <= '0;
      cnt_q     <= '0;
      rxrdy_clr <= 1'b0;
      sbd_set   <= 1'b0;
      ovr_clr   <= 1'b0;
      ardy_set  <= 1'b0;
    end else begin
      buf_q     <= buf_d;
      cnt_q     <= cnt_d;
      rxrdy_clr <= emptied;
      sbd_set   <= lone;
      ovr_clr   <= rd_en;
      ardy_set  <= emptied && mst_rx;
    end
  end

  assign rx_cnt = cnt_q;
endmodule

// File: rtl/bytepack_buf.sv
module bytepack_buf #(
  parameter int NB = 4,
  localparam int CW = $clog2(NB + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_swap,
  input  logic           mst_rx,
  input  logic           wr_valid,
  output logic           wr_ready,
  input  logic           wr_byte,
  input  logic [15:0]    wr_data,
  output logic           pop_valid,
  input  logic           pop_ready,
  output logic [7:0]     pop_data,
  input  logic           push_valid,
  output logic           push_ready,
  input  logic [7:0]     push_data,
  input  logic           rd_en,
  output logic [15:0]    rd_data,
  output logic [CW-1:0]  tx_cnt,
  output logic [CW-1:0]  rx_cnt,
  output logic           txudf_clr,
  output logic           txrdy_clr,
  output logic           rxrdy_clr,
  output logic           sbd_set,
  output logic           ovr_clr,
  output logic           ardy_set
);
  bpk_tx_side #(.NB(NB)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_swap  (cfg_swap),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_byte   (wr_byte),
    .wr_data   (wr_data),
    .pop_valid (pop_valid),
    .pop_ready (pop_ready),
    .pop_data  (pop_data),
    .tx_cnt    (tx_cnt),
    .txudf_clr (txudf_clr),
    .txrdy_clr (txrdy_clr)
  );

  bpk_rx_side #(.NB(NB)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_swap   (cfg_swap),
    .mst_rx     (mst_rx),
    .push_valid (push_valid),
    .push_ready (push_ready),
    .push_data  (push_data),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .rx_cnt     (rx_cnt),
    .rxrdy_clr  (rxrdy_clr),
    .sbd_set    (sbd_set),
    .ovr_clr    (ovr_clr),
    .ardy_set   (ardy_set)
  );
endmodule

// File: rtl/bytepack_buf_chk.sv
module bytepack_buf_chk #(
  parameter int NB = 4,
  localparam int CW = $clog2(NB + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          wr_byte,
  input logic          pop_valid,
  input logic          pop_ready,
  input logic          push_valid,
  input logic          rd_en,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          rxrdy_clr,
  input logic          sbd_set,
  input logic          ovr_clr,
  input logic          ardy_set,
  input logic          txudf_clr
);
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(NB)); // R2
  AST_WORD_ADDS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !wr_byte && !(pop_valid && pop_ready))
      |=> tx_cnt == $past(tx_cnt) + CW'(2)); // R2
  AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> txudf_clr); // R6
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(NB)); // R7
  AST_LONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rx_cnt == CW'(1)) |=> sbd_set); // R9
  AST_ARDY_WITH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ardy_set |-> rxrdy_clr); // R10
  AST_READ_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> ovr_clr); // R11
  AST_EMPTY_READ_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rx_cnt == '0 && !push_valid)
      |=> (rx_cnt == '0 && !rxrdy_clr && !sbd_set)); // R12
endmodule

bind bytepack_buf bytepack_buf_chk #(.NB(NB)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_byte    (wr_byte),
  .pop_valid  (pop_valid),
  .pop_ready  (pop_ready),
  .push_valid (push_valid),
  .rd_en      (rd_en),
  .tx_cnt     (tx_cnt),
  .rx_cnt     (rx_cnt),
  .rxrdy_clr  (rxrdy_clr),
  .sbd_set    (sbd_set),
  .ovr_clr    (ovr_clr),
  .ardy_set   (ardy_set),
  .txudf_clr  (txudf_clr)
);

// File: tb/bytepack_buf_test.sv
`timescale 1ns/1ps
module bytepack_buf_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_swap = 1'b0, mst_rx = 1'b0;
  logic        wr_valid = 1'b0, wr_byte = 1'b0;
  logic [15:0] wr_data = '0;
  logic        pop_ready = 1'b0, push_valid = 1'b0, rd_en = 1'b0;
  logic [7:0]  push_data = '0;
  logic        wr_ready, pop_valid, push_ready;
  logic [7:0]  pop_data;
  logic [15:0] rd_data;
  logic [2:0]  tx_cnt, rx_cnt;
  logic        txudf_clr, txrdy_clr, rxrdy_clr, sbd_set, ovr_clr, ardy_set;

  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  bytepack_buf uut (.*);

  // Behavioural reference model
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic e_udf = 0, e_trdy = 0, e_rrdy = 0, e_sbd = 0, e_ovr = 0, e_ardy = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      {e_udf, e_trdy, e_rrdy, e_sbd, e_ovr, e_ardy} = '0;
    end else begin
      int tn, rn;
      bit acc, emp;
      tn  = txq.size();
      acc = wr_valid && (tn <= 2);
      if (pop_ready && tn > 0) void'(txq.pop_front());
      if (acc) begin
        if (wr_byte) txq.push_back(wr_data[7:0]);
        else if (cfg_swap) begin txq.push_back(wr_data[15:8]); txq.push_back(wr_data[7:0]); end
        else begin txq.push_back(wr_data[7:0]); txq.push_back(wr_data[15:8]); end
      end
      e_udf  = acc;
      e_trdy = acc && (tn + (wr_byte ? 1 : 2)) > 2;
      rn    = rxq.size();
      e_ovr = rd_en;
      e_sbd = rd_en && rn == 1;
      if (rd_en && rn >= 1) void'(rxq.pop_front());
      if (rd_en && rn >= 2) void'(rxq.pop_front());
      emp    = rd_en && rn > 0 && rxq.size() == 0;
      e_rrdy = emp;
      e_ardy = emp && mst_rx;
      if (push_valid && rn < 4) rxq.push_back(push_data);
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [15:0] erd;
    if (rxq.size() == 0) erd = '0;
    else if (rxq.size() == 1) erd = cfg_swap ? {rxq[0], 8'h00} : {8'h00, rxq[0]};
    else erd = cfg_swap ? {rxq[0], rxq[1]} : {rxq[1], rxq[0]};
    chk("R2", "wr_ready", 32'(wr_ready), 32'(txq.size() <= 2));
    chk("R2,R4", "tx_cnt", 32'(tx_cnt), 32'(txq.size()));
    chk("R5", "pop_valid", 32'(pop_valid), 32'(txq.size() != 0));
    if (txq.size() != 0) chk("R3,R4,R5", "pop_data", 32'(pop_data), 32'(txq[0]));
    chk("R7", "push_ready", 32'(push_ready), 32'(rxq.size() < 4));
    chk("R7,R8,R12", "rx_cnt", 32'(rx_cnt), 32'(rxq.size()));
    chk("R8,R9,R12", "rd_data", 32'(rd_data), 32'(erd));
    chk("R6", "txudf_clr", 32'(txudf_clr), 32'(e_udf));
    chk("R6", "txrdy_clr", 32'(txrdy_clr), 32'(e_trdy));
    chk("R9", "sbd_set", 32'(sbd_set), 32'(e_sbd));
    chk("R10", "rxrdy_clr", 32'(rxrdy_clr), 32'(e_rrdy));
    chk("R10", "ardy_set", 32'(ardy_set), 32'(e_ardy));
    chk("R11", "ovr_clr", 32'(ovr_clr), 32'(e_ovr));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    wr_valid = 0; pop_ready = 0; push_valid = 0; rd_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "tx_cnt", 32'(tx_cnt), 0);
    chk("R1", "rx_cnt", 32'(rx_cnt), 0);
    chk("R1", "wr_ready", 32'(wr_ready), 1);
    chk("R1", "push_ready", 32'(push_ready), 1);
    chk("R1", "pop_valid", 32'(pop_valid), 0);
    chk("R1", "rd_data", 32'(rd_data), 0);
    chk("R1", "pulses", 32'({txudf_clr, txrdy_clr, rxrdy_clr, sbd_set, ovr_clr, ardy_set}), 0);
    rst_n = 1;
    tick();
    // R3: word writes in both orders, then fill past the limit (R2 ignore)
    wr_valid = 1; wr_byte = 0; wr_data = 16'hBBAA; cfg_swap = 0; tick();
    wr_data = 16'hDDCC; cfg_swap = 1; tick();
    wr_data = 16'h1111; tick();            // count 4: ignored (R2)
    wr_byte = 1; wr_data = 16'h0022; tick(); // ignored as well
    idle(); pop_ready = 1; repeat (5) tick();
    // R4: word then trailing byte, popping at the same time (R5)
    pop_ready = 0; wr_valid = 1; wr_byte = 0; cfg_swap = 0; wr_data = 16'h3344; tick();
    wr_byte = 1; wr_data = 16'h0055; pop_ready = 1; tick();
    idle(); pop_ready = 1; repeat (4) tick();
    // R12: read of empty buffer, R11 pulse
    idle(); rd_en = 1; tick();
    // R7/R8: fill four, overfill refused, read in both orders
    idle(); push_valid = 1;
    for (int i = 0; i < 5; i++) begin push_data = 8'(8'hA0 + i); tick(); end
    idle(); cfg_swap = 0; rd_en = 1; mst_rx = 1; tick();
    cfg_swap = 1; tick();                   // empties, ardy (R10)
    // R9: three bytes, read two, then lone byte in both orders
    idle(); mst_rx = 0; push_valid = 1;
    for (int i = 0; i < 3; i++) begin push_data = 8'(8'h50 + i); tick(); end
    idle(); rd_en = 1; cfg_swap = 0; tick();
    cfg_swap = 1; tick();
    idle(); tick();
    // Random traffic
    for (int c = 0; c < 4000; c++) begin
      wr_valid   = ($urandom % 3) == 0;
      wr_byte    = ($urandom % 4) == 0;
      wr_data    = 16'($urandom);
      pop_ready  = ($urandom % 2) == 0;
      push_valid = ($urandom % 2) == 0;
      push_data  = 8'($urandom);
      rd_en      = ($urandom % 3) == 0;
      mst_rx     = ($urandom % 2) == 0;
      if ((c % 64) == 0) cfg_swap = ~cfg_swap;
      tick();
    end
    idle(); tick();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL all watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule